// File: doc/BRIEF.md
# Descriptor-Chained DMA Channel Sequencer

This block controls one DMA channel. Software selects a descriptor format, points the channel at a first address and raises an enable bit. The channel then reads descriptors through a memory read port, loads its working address, length and interrupt settings from them, and moves the buffer one word at a time. Each word is one accepted source read followed by one accepted destination write. When a buffer ends, the channel follows the descriptor's link pointer to the next descriptor, or it stops.

Three formats are supported. A register-only mode takes the buffer address, length and fractional-interrupt setting straight from the configuration inputs and runs one buffer. A ring mode fetches two-word descriptors of the form link then buffer address. The length and fractional setting stay fixed on the inputs for the whole run, so a closed ring of two descriptors gives ping-pong buffering. A list mode fetches four-word descriptors that carry link, address, length and a configuration word, so each buffer is fully self-described.

Besides the end-of-buffer interrupt, the channel can pulse an interrupt when half or a quarter of the current buffer remains. A zero length halts the channel with an error flag. Clearing the enable lets the word in flight finish and then stops the channel.

The parameters are the address width AW, the data word width DW and the length width LW. DW must be larger than both AW and LW.

Top module: `dma_chain_seq`

## Requirements
- R1: In mode 0 (register-only), a rising edge of the enable moves cfg_len_i words. The source reads start at cfg_first_i at ascending addresses, and each read datum is written out unchanged before the next read is issued. The channel then goes idle.
- R2: In mode 1 (ring), each descriptor is two words: word 0 is the link and word 1 is the buffer address. The length comes from cfg_len_i and the fractional setting from cfg_frac_i. After each buffer the channel fetches the descriptor at the link and keeps going while the enable stays high.
- R3: In mode 2 (list), each descriptor is four words: link, buffer address, length (bits LW-1:0) and a configuration word. In the configuration word, bit 0 is stop and bits 2:1 select the fractional interrupt. With stop clear, the channel follows the link after the buffer.
- R4: In mode 2, a descriptor whose stop bit is set ends the run after its buffer. No further descriptor read is issued and busy_o falls.
- R5: Descriptor words are read one per accepted read, at ascending addresses starting at the descriptor pointer. While a request waits for rd_ack_i, rd_req_o and rd_addr_o hold steady.
- R6: irq_done_o pulses for exactly one cycle, in the cycle after the accepted write that brings the remaining count to zero, once per completed buffer.
- R7: The fractional setting is 0 for none, 1 for half and 2 for quarter; 3 means none. irq_frac_o pulses for one cycle after the write that leaves remaining = length>>1 (half) or length>>2 (quarter). It does not pulse when that threshold is zero.
- R8: A zero length, from cfg_len_i in mode 0 or from a fetched descriptor, sets err_o and halts the channel with no data read or written. err_o clears on the next start.
- R9: Clearing the enable lets the write of the word in flight complete. After that no further read is issued, no irq_done_o is raised for the cut buffer, and busy_o falls.
- R10: Mode 3 is reserved: an enable edge with mode 3 issues no read and leaves busy_o low.
- R11: Descriptor fetch and data reads share one read port and never request it in the same cycle. Reads and writes never overlap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_enable_i | input | 1 | Channel enable; a rising edge starts, low aborts |
| cfg_mode_i | input | 2 | 0 register-only, 1 ring, 2 list, 3 reserved |
| cfg_first_i | input | AW | First descriptor pointer (modes 1, 2) or buffer address (mode 0) |
| cfg_len_i | input | LW | Buffer length in words for modes 0 and 1 |
| cfg_frac_i | input | 2 | Fractional interrupt select for modes 0 and 1 |
| rd_req_o | output | 1 | Memory read request |
| rd_addr_o | output | AW | Memory read word address |
| rd_ack_i | input | 1 | Read accepted; rd_data_i valid this cycle |
| rd_data_i | input | DW | Read data |
| wr_req_o | output | 1 | Destination write request |
| wr_data_o | output | DW | Destination write data |
| wr_ack_i | input | 1 | Write accepted |
| irq_done_o | output | 1 | One-cycle buffer completion pulse |
| irq_frac_o | output | 1 | One-cycle half or quarter point pulse |
| err_o | output | 1 | Zero-length error flag |
| busy_o | output | 1 | Channel active |

## Verification
The bench builds the channel with AW=8, LW=8 and DW=32. The whole address space then fits in a 256-word memory model, so descriptor chains, rings that wrap back to their first descriptor, and buffers can sit side by side at hand-chosen addresses. Short lengths of 1 to 10 words bring the corner cases within reach: the zero-threshold case of the fractional interrupt, the quarter and half points, the zero-length error, and an abort in the middle of a buffer. Pseudo-random accept patterns on both ports exercise stalls during descriptor fetch and data movement.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

    typedef enum logic [1:0] {
        MODE_REG  = 2'd0,
        MODE_RING = 2'd1,
        MODE_LIST = 2'd2,
        MODE_RSVD = 2'd3
    } chan_mode_e;

    typedef enum logic [1:0] {
        FRAC_NONE    = 2'd0,
        FRAC_HALF    = 2'd1,
        FRAC_QUARTER = 2'd2,
        FRAC_RSVD    = 2'd3
    } frac_sel_e;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_FETCH = 2'd1,
        SQ_XFER  = 2'd2
    } seq_state_e;

    typedef enum logic [1:0] {
        EN_IDLE  = 2'd0,
        EN_READ  = 2'd1,
        EN_WRITE = 2'd2
    } eng_state_e;

    localparam int DESC_MAX_WORDS = 4;
    localparam int CFG_STOP_BIT   = 0;
    localparam int CFG_FRAC_LSB   = 1;

endpackage

// File: rtl/dma_desc_fetch.sv
module dma_desc_fetch
    import dma_seq_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 32
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           start_i,
    input  logic [AW-1:0]                  base_i,
    input  logic                           four_word_i,
    output logic                           rd_req_o,
    output logic [AW-1:0]                  rd_addr_o,
    input  logic                           rd_ack_i,
    input  logic [DW-1:0]                  rd_data_i,
    output logic                           done_o,
    output logic [DESC_MAX_WORDS-1:0][DW-1:0] words_o
);
    localparam int IW = $clog2(DESC_MAX_WORDS);

    typedef struct packed {
        logic                              active;
        logic                              four;
        logic [IW-1:0]                     idx;
        logic [AW-1:0]                     base;
        logic                              done;
        logic [DESC_MAX_WORDS-1:0][DW-1:0] words;
    } fetch_reg_t;

    fetch_reg_t q, d;
    logic [IW-1:0] last_idx;
    logic          last_word;

    always_comb begin
        last_idx  = q.four ? IW'(DESC_MAX_WORDS - 1) : IW'(1);
        last_word = (q.idx == last_idx);
        d         = q;
        d.done    = 1'b0;
        if (start_i) begin
            d.active = 1'b1;
            d.four   = four_word_i;
            d.idx    = '0;
            d.base   = base_i;
        end else if (q.active && rd_ack_i) begin
            d.words[q.idx] = rd_data_i;
            if (last_word) begin
                d.active = 1'b0;
                d.done   = 1'b1;
            end else begin
                d.idx = q.idx + IW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rd_req_o  = q.active;
    assign rd_addr_o = q.base + AW'(q.idx);
    assign done_o    = q.done;
    assign words_o   = q.words;

    // R5
    fetch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o && !rd_ack_i) |=> (rd_req_o && $stable(rd_addr_o)));

    // R5
    fetch_ascend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o && rd_ack_i && !last_word) |=> (rd_addr_o == $past(rd_addr_o) + AW'(1)));

endmodule

// File: rtl/dma_xfer_engine.sv
module dma_xfer_engine
    import dma_seq_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 32,
    parameter int LW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [AW-1:0] addr_i,
    input  logic [LW-1:0] len_i,
    input  logic          abort_i,
    output logic          rd_req_o,
    output logic [AW-1:0] rd_addr_o,
    input  logic          rd_ack_i,
    input  logic [DW-1:0] rd_data_i,
    output logic          wr_req_o,
    output logic [DW-1:0] wr_data_o,
    input  logic          wr_ack_i,
    output logic [LW-1:0] remain_o,
    output logic          wr_fire_o,
    output logic          done_o
);
    typedef struct packed {
        eng_state_e    st;
        logic [AW-1:0] addr;
        logic [LW-1:0] cnt;
        logic [DW-1:0] data;
        logic          done;
    } eng_reg_t;

    eng_reg_t q, d;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        case (q.st)
            EN_IDLE: begin
                if (load_i) begin
                    d.addr = addr_i;
                    d.cnt  = len_i;
                    d.st   = EN_READ;
                end
            end
            EN_READ: begin
                if (abort_i) begin
                    d.st   = EN_IDLE;
                    d.done = 1'b1;
                end else if (rd_ack_i) begin
                    d.data = rd_data_i;
                    d.addr = q.addr + AW'(1);
                    d.st   = EN_WRITE;
                end
            end
            EN_WRITE: begin
                if (wr_ack_i) begin
                    d.cnt = q.cnt - LW'(1);
                    if (q.cnt == LW'(1)) begin
                        d.st   = EN_IDLE;
                        d.done = 1'b1;
                    end else begin
                        d.st = EN_READ;
                    end
                end
            end
            default: d.st = EN_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rd_req_o  = (q.st == EN_READ) && !abort_i;
    assign rd_addr_o = q.addr;
    assign wr_req_o  = (q.st == EN_WRITE);
    assign wr_data_o = q.data;
    assign wr_fire_o = wr_req_o && wr_ack_i;
    assign remain_o  = q.cnt;
    assign done_o    = q.done;

    // R1
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req_o && !wr_ack_i) |=> (wr_req_o && $stable(wr_data_o)));

    // R11
    rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o && rd_ack_i) |=> !rd_req_o);

    // R1
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_fire_o |=> (remain_o == $past(remain_o) - LW'(1)));

endmodule

// File: rtl/dma_irq_gen.sv
module dma_irq_gen
    import dma_seq_pkg::*;
#(
    parameter int LW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [LW-1:0] len_i,
    input  logic [1:0]    frac_i,
    input  logic          wr_fire_i,
    input  logic [LW-1:0] remain_i,
    output logic          irq_done_o,
    output logic          irq_frac_o
);
    typedef struct packed {
        logic [LW-1:0] thr;
        logic          done;
        logic          frac;
    } irq_reg_t;

    irq_reg_t q, d;
    logic [LW-1:0] next_remain;

    always_comb begin
        next_remain = remain_i - LW'(1);
        d           = q;
        d.done      = wr_fire_i && (remain_i == LW'(1));
        d.frac      = wr_fire_i && (q.thr != '0) && (next_remain == q.thr);
        if (load_i) begin
            case (frac_sel_e'(frac_i))
                FRAC_HALF:    d.thr = len_i >> 1;
                FRAC_QUARTER: d.thr = len_i >> 2;
                default:      d.thr = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign irq_done_o = q.done;
    assign irq_frac_o = q.frac;

    // R6
    done_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_done_o |-> $past(wr_fire_i));

    // R6
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_done_o |=> !irq_done_o);

    // R7
    frac_not_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_done_o && irq_frac_o));

endmodule

// File: rtl/dma_chain_seq.sv
module dma_chain_seq
    import dma_seq_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 32,
    parameter int LW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_enable_i,
    input  logic [1:0]    cfg_mode_i,
    input  logic [AW-1:0] cfg_first_i,
    input  logic [LW-1:0] cfg_len_i,
    input  logic [1:0]    cfg_frac_i,
    output logic          rd_req_o,
    output logic [AW-1:0] rd_addr_o,
    input  logic          rd_ack_i,
    input  logic [DW-1:0] rd_data_i,
    output logic          wr_req_o,
    output logic [DW-1:0] wr_data_o,
    input  logic          wr_ack_i,
    output logic          irq_done_o,
    output logic          irq_frac_o,
    output logic          err_o,
    output logic          busy_o
);
    typedef struct packed {
        seq_state_e    st;
        chan_mode_e    mode;
        logic          en;
        logic          err;
        logic [AW-1:0] link;
        logic          stop;
    } seq_reg_t;

    seq_reg_t q, d;

    logic                              fetch_start, fetch_done, fetch_req;
    logic [AW-1:0]                     fetch_base, fetch_addr;
    logic [DESC_MAX_WORDS-1:0][DW-1:0] desc_words;
    logic                              eng_load, eng_done, eng_req, eng_fire;
    logic [AW-1:0]                     eng_addr_ld, eng_addr;
    logic [LW-1:0]                     eng_len, eng_remain;
    logic [1:0]                        eng_frac;
    logic                              start_edge;
    logic                              unused_desc_bits;

    always_comb begin
        d           = q;
        d.en        = cfg_enable_i;
        start_edge  = cfg_enable_i && !q.en;
        fetch_start = 1'b0;
        fetch_base  = cfg_first_i;
        eng_load    = 1'b0;
        eng_addr_ld = cfg_first_i;
        eng_len     = cfg_len_i;
        eng_frac    = cfg_frac_i;
        case (q.st)
            SQ_IDLE: begin
                if (start_edge) begin
                    d.err  = 1'b0;
                    d.mode = chan_mode_e'(cfg_mode_i);
                    case (chan_mode_e'(cfg_mode_i))
                        MODE_REG: begin
                            d.stop = 1'b1;
                            if (cfg_len_i == '0) begin
                                d.err = 1'b1;
                            end else begin
                                eng_load = 1'b1;
                                d.st     = SQ_XFER;
                            end
                        end
                        MODE_RING, MODE_LIST: begin
                            fetch_start = 1'b1;
                            d.st        = SQ_FETCH;
                        end
                        default: d.st = SQ_IDLE;
                    endcase
                end
            end
            SQ_FETCH: begin
                if (q.mode == MODE_LIST) begin
                    eng_len  = desc_words[2][LW-1:0];
                    eng_frac = desc_words[3][CFG_FRAC_LSB+1:CFG_FRAC_LSB];
                end
                eng_addr_ld = desc_words[1][AW-1:0];
                if (fetch_done) begin
                    d.link = desc_words[0][AW-1:0];
                    d.stop = (q.mode == MODE_LIST) && desc_words[3][CFG_STOP_BIT];
                    if (!cfg_enable_i) begin
                        d.st = SQ_IDLE;
                    end else if (eng_len == '0) begin
                        d.err = 1'b1;
                        d.st  = SQ_IDLE;
                    end else begin
                        eng_load = 1'b1;
                        d.st     = SQ_XFER;
                    end
                end
            end
            SQ_XFER: begin
                if (eng_done) begin
                    if (!cfg_enable_i || q.stop) begin
                        d.st = SQ_IDLE;
                    end else begin
                        fetch_start = 1'b1;
                        fetch_base  = q.link;
                        d.st        = SQ_FETCH;
                    end
                end
            end
            default: d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    dma_desc_fetch #(.AW(AW), .DW(DW)) u_fetch (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (fetch_start),
        .base_i      (fetch_base),
        .four_word_i (d.mode == MODE_LIST),
        .rd_req_o    (fetch_req),
        .rd_addr_o   (fetch_addr),
        .rd_ack_i    (rd_ack_i && fetch_req),
        .rd_data_i   (rd_data_i),
        .done_o      (fetch_done),
        .words_o     (desc_words)
    );

    dma_xfer_engine #(.AW(AW), .DW(DW), .LW(LW)) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (eng_load),
        .addr_i    (eng_addr_ld),
        .len_i     (eng_len),
        .abort_i   (!cfg_enable_i),
        .rd_req_o  (eng_req),
        .rd_addr_o (eng_addr),
        .rd_ack_i  (rd_ack_i && eng_req),
        .rd_data_i (rd_data_i),
        .wr_req_o  (wr_req_o),
        .wr_data_o (wr_data_o),
        .wr_ack_i  (wr_ack_i),
        .remain_o  (eng_remain),
        .wr_fire_o (eng_fire),
        .done_o    (eng_done)
    );

    dma_irq_gen #(.LW(LW)) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (eng_load),
        .len_i      (eng_len),
        .frac_i     (eng_frac),
        .wr_fire_i  (eng_fire),
        .remain_i   (eng_remain),
        .irq_done_o (irq_done_o),
        .irq_frac_o (irq_frac_o)
    );

    assign rd_req_o  = fetch_req || eng_req;
    assign rd_addr_o = fetch_req ? fetch_addr : eng_addr;
    assign err_o     = q.err;
    assign busy_o    = (q.st != SQ_IDLE);

    assign unused_desc_bits = ^{desc_words[0][DW-1:AW], desc_words[1][DW-1:AW],
                                desc_words[2][DW-1:LW], desc_words[3][DW-1:CFG_FRAC_LSB+2]};

    // R11
    rd_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fetch_req, eng_req, wr_req_o}));

    // R8
    err_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> !busy_o);

    // R4
    stop_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == SQ_XFER && eng_done && q.stop) |=> (!busy_o && !rd_req_o));

    // R10
    rsvd_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == SQ_IDLE && start_edge && cfg_mode_i == 2'd3) |=> !busy_o);

endmodule

// File: tb/test_dma_chain_seq.sv
module test_dma_chain_seq;
    localparam int AW = 8;
    localparam int DW = 32;
    localparam int LW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_enable_i = 1'b0;
    logic [1:0]    cfg_mode_i = 2'd0;
    logic [AW-1:0] cfg_first_i = '0;
    logic [LW-1:0] cfg_len_i = '0;
    logic [1:0]    cfg_frac_i = 2'd0;
    logic          rd_req_o, wr_req_o, irq_done_o, irq_frac_o, err_o, busy_o;
    logic [AW-1:0] rd_addr_o;
    logic          rd_ack_i = 1'b0, wr_ack_i = 1'b0;
    logic [DW-1:0] rd_data_i, wr_data_o;

    logic [DW-1:0] mem [256];
    assign rd_data_i = mem[rd_addr_o];

    int n_cmp = 0, n_bad = 0, cyc = 0;
    int wr_cnt = 0, done_cnt = 0, frac_cnt = 0, frac_at = -1;
    logic ack_all = 1'b1;
    logic [15:0] lfsr = 16'hACE1;
    logic [AW-1:0] exp_rd [$];
    logic [DW-1:0] exp_wr [$];

    always #5 clk = ~clk;

    dma_chain_seq #(.AW(AW), .DW(DW), .LW(LW)) i_dma_chain_seq (.*);

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary_and_end();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Monitor: drive accepts, then compare handshakes against the scoreboard
    always @(negedge clk) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        rd_ack_i = ack_all ? 1'b1 : lfsr[0];
        wr_ack_i = ack_all ? 1'b1 : lfsr[3];
        #1;
        if (rd_req_o && rd_ack_i) begin
            n_cmp++;
            if (exp_rd.size() == 0) begin
                n_bad++;
                $display("FAIL R5/R1: unexpected read actual %0d expected none", rd_addr_o);
            end else begin
                logic [AW-1:0] e;
                e = exp_rd.pop_front();
                if (rd_addr_o != e) begin
                    n_bad++;
                    $display("FAIL R5/R1: read addr actual %0d expected %0d", rd_addr_o, e);
                end
            end
        end
        if (wr_req_o && wr_ack_i) begin
            wr_cnt++;
            n_cmp++;
            if (exp_wr.size() == 0) begin
                n_bad++;
                $display("FAIL R1: unexpected write actual %0h expected none", wr_data_o);
            end else begin
                logic [DW-1:0] e;
                e = exp_wr.pop_front();
                if (wr_data_o != e) begin
                    n_bad++;
                    $display("FAIL R1: write data actual %0h expected %0h", wr_data_o, e);
                end
            end
        end
        if (irq_done_o) done_cnt++;
        if (irq_frac_o) begin
            frac_cnt++;
            frac_at = wr_cnt;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            summary_and_end();
        end
    end

    task automatic push_desc(input int base, input int n);
        for (int k = 0; k < n; k++) exp_rd.push_back(AW'(base + k));
    endtask

    task automatic push_buf(input int addr, input int len);
        for (int k = 0; k < len; k++) begin
            exp_rd.push_back(AW'(addr + k));
            exp_wr.push_back(mem[addr + k]);
        end
    endtask

    task automatic start(input int mode, input int first, input int len, input int frac);
        @(negedge clk);
        wr_cnt = 0; done_cnt = 0; frac_cnt = 0; frac_at = -1;
        cfg_mode_i = 2'(mode); cfg_first_i = AW'(first);
        cfg_len_i = LW'(len); cfg_frac_i = 2'(frac);
        cfg_enable_i = 1'b1;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic wait_idle();
        while (busy_o) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic stop_en();
        cfg_enable_i = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic end_checks(input string req, input int dones, input int fracs, input int err);
        check({req, " reads drained"}, exp_rd.size(), 0);
        check({req, " writes drained"}, exp_wr.size(), 0);
        check({req, " irq_done count"}, done_cnt, dones);
        check({req, " irq_frac count"}, frac_cnt, fracs);
        check({req, " busy low"}, int'(busy_o), 0);
        check({req, " err"}, int'(err_o), err);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 32'h5A000000 ^ (i * 32'h00010203);
        // list chain: 0x10 -> 0x20 (stop)
        mem[8'h10] = 32'h20; mem[8'h11] = 32'h80; mem[8'h12] = 32'd4; mem[8'h13] = 32'd4;
        mem[8'h20] = 32'h10; mem[8'h21] = 32'h90; mem[8'h22] = 32'd3; mem[8'h23] = 32'd1;
        // ring: 0x30 <-> 0x34
        mem[8'h30] = 32'h34; mem[8'h31] = 32'hA0;
        mem[8'h34] = 32'h30; mem[8'h35] = 32'hB0;
        // zero-length list descriptor
        mem[8'h50] = 32'h00; mem[8'h51] = 32'h80; mem[8'h52] = 32'd0; mem[8'h53] = 32'd0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("reset busy", int'(busy_o), 0);
        check("reset rd_req", int'(rd_req_o), 0);
        check("reset wr_req", int'(wr_req_o), 0);
        check("reset irq", int'(irq_done_o | irq_frac_o), 0);
        check("reset err", int'(err_o), 0);

        // R1 register-only, half point of 5 -> threshold 2 after 3 writes (R7)
        ack_all = 1'b0;
        push_buf(8'h40, 5);
        start(0, 8'h40, 5, 1);
        wait_idle();
        end_checks("R1", 1, 1, 0);
        check("R7 half point write index", frac_at, 3);
        stop_en();

        // R3 list chain with quarter point (len 4 -> threshold 1), R4 stop on second
        push_desc(8'h10, 4); push_buf(8'h80, 4);
        push_desc(8'h20, 4); push_buf(8'h90, 3);
        start(2, 8'h10, 0, 0);
        wait_idle();
        end_checks("R3/R4", 2, 1, 0);
        check("R7 quarter point write index", frac_at, 3);
        stop_en();

        // R2 ring, three buffers then enable cleared at a buffer boundary (R9)
        push_desc(8'h30, 2); push_buf(8'hA0, 2);
        push_desc(8'h34, 2); push_buf(8'hB0, 2);
        push_desc(8'h30, 2); push_buf(8'hA0, 2);
        start(1, 8'h30, 2, 0);
        wait (done_cnt == 3);
        cfg_enable_i = 1'b0;
        wait_idle();
        end_checks("R2", 3, 0, 0);
        stop_en();

        // R9 abort in the middle of a buffer
        ack_all = 1'b1;
        push_buf(8'hC0, 3);
        start(0, 8'hC0, 10, 0);
        wait (wr_cnt == 3);
        @(posedge clk);
        #2 cfg_enable_i = 1'b0;
        wait_idle();
        end_checks("R9", 0, 0, 0);
        check("R9 writes done", wr_cnt, 3);
        stop_en();

        // R8 zero length in fetched descriptor
        ack_all = 1'b0;
        push_desc(8'h50, 4);
        start(2, 8'h50, 0, 0);
        wait_idle();
        end_checks("R8", 0, 0, 1);
        stop_en();

        // R8 err clears on restart; R7 zero threshold (len 1 half) gives no pulse
        push_buf(8'h60, 1);
        start(0, 8'h60, 1, 1);
        wait_idle();
        end_checks("R8/R7", 1, 0, 0);
        stop_en();

        // R8 zero length in register-only mode
        start(0, 8'h60, 0, 0);
        wait_idle();
        end_checks("R8 reg", 0, 0, 1);
        stop_en();

        // R10 reserved mode
        start(3, 8'h10, 4, 0);
        wait_idle();
        end_checks("R10", 0, 0, 0);
        stop_en();

        summary_and_end();
    end
endmodule